// File: doc/BRIEF.md
# Accumulator Processor Core with Double-Indirect Loads

This block is a compact processor core built around one accumulator. Every load, every sum or difference and every store moves through that single register. Instructions are two words long: an 8-bit opcode followed by one operand word. The core reads both words from a synchronous memory port, where read data appears one clock after the address. It then performs at most two more memory accesses to resolve the operand.

Three load flavours differ only in how many times the operand is used as a pointer: none (the operand is the value), once (the operand is the address of the value) and twice (the operand points at a word that holds the address of the value). The program counter has a private incrementer that can only add one. Jumps and returns load it directly. A single return register gives exactly one level of subroutine call. An opcode outside the table stops the core until reset.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high, the accumulator, the saved return address and the program counter are cleared to zero. After release, the first opcode is read from address 0, `mem_we_o` is 0 and `halt_o` is 0.
- R2: Each instruction reads its opcode at the program counter and its operand at the next address. The counter steps by exactly one per word fetched, so the opcode is on `mem_addr_o` in the first cycle after reset release and the operand address is on it in the second.
- R3: Opcode 0x10 (load immediate) places the operand word itself in the accumulator.
- R4: Opcode 0x11 (load direct) places the word stored at the operand address in the accumulator.
- R5: Opcode 0x12 (load double-indirect) reads the word at the operand address, uses that word as a second address, and places the word found there in the accumulator.
- R6: Opcode 0x20 (add) sets the accumulator to accumulator plus the word at the operand address, modulo 2^DW.
- R7: Opcode 0x21 (subtract) sets the accumulator to accumulator plus the bitwise inverse of the word at the operand address plus one, modulo 2^DW. Subtracting zero leaves the value unchanged.
- R8: Opcode 0x30 (store) raises `mem_we_o` for exactly one cycle, with `mem_addr_o` equal to the operand and `mem_wdata_o` equal to the accumulator. The accumulator is not changed by the store.
- R9: Opcode 0x40 (jump) fetches the next opcode from the operand address. The words that follow the jump are never executed.
- R10: Opcode 0x41 (call) saves the address of the word that follows its operand and continues at the operand address.
- R11: Opcode 0x42 (return) continues at the saved address. A call made inside a subroutine replaces the saved address without any indication, so a later return goes to the address after the inner call.
- R12: Any opcode not listed above (for example 0x00 or 0xFF) raises `halt_o`. From then until reset, `halt_o` stays high, `mem_we_o` stays low and `mem_addr_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr_o | output | AW | Memory address for the current access |
| mem_rdata_i | input | DW | Read data, valid one cycle after its address |
| mem_wdata_o | output | DW | Write data (the accumulator) |
| mem_we_o | output | 1 | Write strobe, one cycle per store |
| halt_o | output | 1 | High once an unknown opcode has been fetched |

## Verification
The double-indirect load uses a pointer cell whose content differs from the final data. A core that dereferences only once therefore stores the pointer value instead of the data. An add that wraps past the word width and a subtract that goes below zero expose a missing modulo or a wrong carry-in; a forced carry of zero, for example, stores a result one too low. The call tests return from a nested call and place a store right after each call's operand. A wrong saved address then either repeats the call forever or skips that store, and a core that keeps the outer return address replays an earlier path and produces writes in the wrong order. A return issued straight after reset must loop at address 0, which fails if the return register is not cleared. The halt test watches that nothing is written and the address stays frozen after an unknown opcode.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [7:0] {
    OP_LDI  = 8'h10,
    OP_LDD  = 8'h11,
    OP_LDX  = 8'h12,
    OP_ADD  = 8'h20,
    OP_SUB  = 8'h21,
    OP_STO  = 8'h30,
    OP_JMP  = 8'h40,
    OP_CALL = 8'h41,
    OP_RET  = 8'h42
  } opcode_e;

  typedef enum logic [2:0] {
    ST_OPC,   // opcode address on the bus
    ST_ARG,   // opcode arrives, operand address on the bus
    ST_EXE,   // operand arrives, act on it
    ST_IND,   // first pointer arrives, issue second address
    ST_MEM,   // data word arrives, update accumulator
    ST_HALT
  } state_e;

  function automatic logic op_known(input logic [7:0] code);
    case (code)
      OP_LDI, OP_LDD, OP_LDX, OP_ADD, OP_SUB,
      OP_STO, OP_JMP, OP_CALL, OP_RET: op_known = 1'b1;
      default:                          op_known = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] y_o
);

  // One adder serves both operations: the second input is optionally
  // inverted and the LSB carry-in is forced high for subtraction.
  function automatic logic [DW-1:0] add_core(input logic [DW-1:0] x,
                                             input logic [DW-1:0] z,
                                             input logic          cin);
    add_core = x + z + {{(DW-1){1'b0}}, cin};
  endfunction

  logic [DW-1:0] b_eff;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign y_o   = add_core(a_i, b_eff, sub_i);

endmodule

// File: rtl/acc_pc_unit.sv
module acc_pc_unit #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_i,
  input  logic          load_i,
  input  logic          ret_sel_i,
  input  logic          save_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] ret_o
);

  // The only arithmetic on the counter: add exactly one.
  function automatic logic [AW-1:0] step_one(input logic [AW-1:0] x);
    step_one = x + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  logic [AW-1:0] pc_q;
  logic [AW-1:0] ret_q;
  logic [AW-1:0] pc_plus1;
  logic [AW-1:0] pc_d;

  assign pc_plus1 = step_one(pc_q);

  always_comb begin
    pc_d = pc_q;
    if (load_i)         pc_d = target_i;
    else if (ret_sel_i) pc_d = ret_q;
    else if (inc_i)     pc_d = pc_plus1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ret_q <= '0;
    end else begin
      pc_q <= pc_d;
      if (save_i) ret_q <= pc_q;
    end
  end

  assign pc_o  = pc_q;
  assign ret_o = ret_q;

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] rdata_i,
  output logic [7:0]    ir_o,
  output logic          pc_inc_o,
  output logic          pc_load_o,
  output logic          pc_ret_o,
  output logic          ret_save_o,
  output logic          acc_load_o,
  output logic          acc_from_alu_o,
  output logic          alu_sub_o,
  output logic          addr_from_data_o,
  output logic          we_o,
  output logic          halt_o
);

  state_e  state_q, state_d;
  opcode_e ir_q;
  logic    ir_load;
  logic    opc_ok;

  assign opc_ok = op_known(rdata_i[7:0]);

  always_comb begin
    state_d          = state_q;
    ir_load          = 1'b0;
    pc_inc_o         = 1'b0;
    pc_load_o        = 1'b0;
    pc_ret_o         = 1'b0;
    ret_save_o       = 1'b0;
    acc_load_o       = 1'b0;
    acc_from_alu_o   = 1'b0;
    alu_sub_o        = 1'b0;
    addr_from_data_o = 1'b0;
    we_o             = 1'b0;
    case (state_q)
      ST_OPC: begin
        pc_inc_o = 1'b1;
        state_d  = ST_ARG;
      end
      ST_ARG: begin
        if (opc_ok) begin
          ir_load  = 1'b1;
          pc_inc_o = 1'b1;
          state_d  = ST_EXE;
        end else begin
          state_d = ST_HALT;
        end
      end
      ST_EXE: begin
        state_d = ST_OPC;
        case (ir_q)
          OP_LDI: acc_load_o = 1'b1;
          OP_LDD, OP_ADD, OP_SUB: begin
            addr_from_data_o = 1'b1;
            state_d          = ST_MEM;
          end
          OP_LDX: begin
            addr_from_data_o = 1'b1;
            state_d          = ST_IND;
          end
          OP_STO: begin
            addr_from_data_o = 1'b1;
            we_o             = 1'b1;
          end
          OP_JMP: pc_load_o = 1'b1;
          OP_CALL: begin
            ret_save_o = 1'b1;
            pc_load_o  = 1'b1;
          end
          OP_RET: pc_ret_o = 1'b1;
          default: state_d = ST_HALT;
        endcase
      end
      ST_IND: begin
        addr_from_data_o = 1'b1;
        state_d          = ST_MEM;
      end
      ST_MEM: begin
        acc_load_o     = 1'b1;
        acc_from_alu_o = (ir_q == OP_ADD) || (ir_q == OP_SUB);
        alu_sub_o      = (ir_q == OP_SUB);
        state_d        = ST_OPC;
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OPC;
      ir_q    <= OP_LDI;
    end else begin
      state_q <= state_d;
      if (ir_load) ir_q <= opcode_e'(rdata_i[7:0]);
    end
  end

  assign ir_o   = ir_q;
  assign halt_o = (state_q == ST_HALT);

endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int DW = 8,
  parameter int AW = DW
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          halt_o
);

  logic [DW-1:0] acc_q;
  logic [DW-1:0] alu_y;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] ret_q;
  logic [AW-1:0] data_addr;
  logic [7:0]    ir_q;

  // named internal events, observed by the bound checker
  logic pc_inc_ev;
  logic pc_load_ev;
  logic ret_ev;
  logic call_ev;
  logic acc_load_ev;
  logic acc_from_alu;
  logic alu_sub;
  logic addr_from_data;

  assign data_addr = mem_rdata_i[AW-1:0];

  acc_ctrl #(.DW(DW)) u_ctrl (
    .clk              (clk),
    .rst              (rst),
    .rdata_i          (mem_rdata_i),
    .ir_o             (ir_q),
    .pc_inc_o         (pc_inc_ev),
    .pc_load_o        (pc_load_ev),
    .pc_ret_o         (ret_ev),
    .ret_save_o       (call_ev),
    .acc_load_o       (acc_load_ev),
    .acc_from_alu_o   (acc_from_alu),
    .alu_sub_o        (alu_sub),
    .addr_from_data_o (addr_from_data),
    .we_o             (mem_we_o),
    .halt_o           (halt_o)
  );

  acc_pc_unit #(.AW(AW)) u_pc (
    .clk       (clk),
    .rst       (rst),
    .inc_i     (pc_inc_ev),
    .load_i    (pc_load_ev),
    .ret_sel_i (ret_ev),
    .save_i    (call_ev),
    .target_i  (data_addr),
    .pc_o      (pc_q),
    .ret_o     (ret_q)
  );

  acc_alu #(.DW(DW)) u_alu (
    .a_i   (acc_q),
    .b_i   (mem_rdata_i),
    .sub_i (alu_sub),
    .y_o   (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst)              acc_q <= '0;
    else if (acc_load_ev) acc_q <= acc_from_alu ? alu_y : mem_rdata_i;
  end

  assign mem_addr_o  = addr_from_data ? data_addr : pc_q;
  assign mem_wdata_o = acc_q;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DW = 8,
  parameter int AW = DW
) (
  input logic          clk,
  input logic          rst,
  input logic          halt,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] ret,
  input logic [DW-1:0] acc,
  input logic [7:0]    ir,
  input logic          pc_step,
  input logic          call_ev,
  input logic          ret_ev
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: state cleared after a reset cycle
  always_ff @(posedge clk) begin
    if (rst_d) begin
      assert_reset_clear_R1: assert (pc == '0 && acc == '0 && ret == '0 && !halt);
    end
  end

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    pc_step |=> pc == $past(pc) + 1'b1);

  assert_store_only_R8: assert property (@(posedge clk) disable iff (rst)
    we |-> ir == 8'h30);

  assert_store_keeps_acc_R8: assert property (@(posedge clk) disable iff (rst)
    we |=> acc == $past(acc));

  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    we |=> !we);

  assert_call_saves_R10: assert property (@(posedge clk) disable iff (rst)
    call_ev |=> ret == $past(pc));

  assert_ret_restores_R11: assert property (@(posedge clk) disable iff (rst)
    ret_ev |=> pc == $past(ret));

  assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt && $stable(addr));

  assert_halt_no_write_R12: assert property (@(posedge clk) disable iff (rst)
    halt |-> !we);

endmodule

bind acc_core acc_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .halt    (halt_o),
  .we      (mem_we_o),
  .addr    (mem_addr_o),
  .pc      (pc_q),
  .ret     (ret_q),
  .acc     (acc_q),
  .ir      (ir_q),
  .pc_step (pc_inc_ev),
  .call_ev (call_ev),
  .ret_ev  (ret_ev)
);

// File: tb/test_acc_core.sv
module test_acc_core;

  localparam int DW = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_rdata_i;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_we_o;
  logic          halt_o;

  logic [DW-1:0] mem [256];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [AW+DW-1:0] exp_q [$];
  string            tag_q [$];

  always #5 clk = ~clk;

  acc_core #(.DW(DW), .AW(AW)) i_acc_core (
    .clk         (clk),
    .rst         (rst),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .halt_o      (halt_o)
  );

  // synchronous memory model
  always @(posedge clk) begin
    if (mem_we_o && !rst) mem[mem_addr_o] <= mem_wdata_o;
    mem_rdata_i <= mem[mem_addr_o];
  end

  task automatic check(input bit ok, input string tag,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver side: expected writes
  task automatic expect_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input string tag);
    exp_q.push_back({a, d});
    tag_q.push_back(tag);
  endtask

  // monitor side: compare every write strobe against the queue
  always @(negedge clk) begin
    if (!rst && mem_we_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected write", int'({mem_addr_o, mem_wdata_o}), 0);
      end else begin
        logic [AW+DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({mem_addr_o, mem_wdata_o} == e, t,
              int'({mem_addr_o, mem_wdata_o}), int'(e));
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic poke(input int a, input int op, input int arg);
    mem[a]   = op[7:0];
    mem[a+1] = arg[7:0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_to_halt(input string tag);
    int n = 0;
    while (!halt_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(halt_o == 1'b1, tag, int'(halt_o), 1);
    check(exp_q.size() == 0, {tag, " pending writes"}, exp_q.size(), 0);
  endtask

  initial begin
    logic [AW-1:0] frozen;

    // ---------- program 1: loads, arithmetic, stores ----------
    clear_mem();
    poke(8'h00, 8'h30, 8'h90);  // STO: acc after reset
    poke(8'h02, 8'h10, 8'h5A);  // LDI
    poke(8'h04, 8'h30, 8'h91);
    poke(8'h06, 8'h11, 8'h80);  // LDD
    poke(8'h08, 8'h30, 8'h92);
    poke(8'h0A, 8'h12, 8'h81);  // LDX
    poke(8'h0C, 8'h30, 8'h93);
    poke(8'h0E, 8'h20, 8'h82);  // ADD wraps
    poke(8'h10, 8'h30, 8'h94);
    poke(8'h12, 8'h21, 8'h83);  // SUB below zero
    poke(8'h14, 8'h30, 8'h95);
    poke(8'h16, 8'h21, 8'h85);  // SUB zero
    poke(8'h18, 8'h30, 8'h96);
    poke(8'h1A, 8'h30, 8'h97);  // second store, acc unchanged
    poke(8'h1C, 8'hFF, 8'h00);  // unknown opcode
    mem[8'h80] = 8'h3C;
    mem[8'h81] = 8'h84;         // pointer
    mem[8'h84] = 8'hA7;         // final data
    mem[8'h82] = 8'h6B;
    mem[8'h83] = 8'h20;
    mem[8'h85] = 8'h00;

    expect_wr(8'h90, 8'h00, "R1 reset acc");
    expect_wr(8'h91, 8'h5A, "R3 immediate");
    expect_wr(8'h92, 8'h3C, "R4 direct");
    expect_wr(8'h93, 8'hA7, "R5 double-indirect");
    expect_wr(8'h94, 8'h12, "R6 add wrap");
    expect_wr(8'h95, 8'hF2, "R7 sub borrow");
    expect_wr(8'h96, 8'hF2, "R7 sub zero");
    expect_wr(8'h97, 8'hF2, "R8 acc kept");

    do_reset();
    // first cycle after release: opcode address
    check(mem_addr_o == 8'h00, "R1 first fetch", int'(mem_addr_o), 0);
    check(mem_we_o == 1'b0 && halt_o == 1'b0, "R1 idle outputs",
          int'({mem_we_o, halt_o}), 0);
    @(negedge clk);
    check(mem_addr_o == 8'h01, "R2 operand fetch", int'(mem_addr_o), 1);
    run_to_halt("R12 halt after 0xFF");

    frozen = mem_addr_o;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(halt_o && !mem_we_o && mem_addr_o == frozen,
            "R12 halted frozen", int'(mem_addr_o), int'(frozen));
    end
    check(mem[8'h97] == 8'hF2, "R8 memory written", int'(mem[8'h97]), 'hF2);

    // ---------- program 2: jump, call, nested call, return ----------
    clear_mem();
    poke(8'h00, 8'h40, 8'h10);  // JMP 10
    poke(8'h02, 8'h30, 8'hEE);  // skipped
    poke(8'h10, 8'h10, 8'h11);
    poke(8'h12, 8'h41, 8'h30);  // CALL 30, return to 14
    poke(8'h14, 8'h30, 8'hA1);
    poke(8'h16, 8'h41, 8'h40);  // CALL 40
    poke(8'h18, 8'h30, 8'hA3);
    poke(8'h1A, 8'h00, 8'h00);  // unknown opcode 0x00
    poke(8'h30, 8'h10, 8'h22);
    poke(8'h32, 8'h42, 8'h00);  // RET
    poke(8'h40, 8'h41, 8'h50);  // nested CALL overwrites saved address
    poke(8'h42, 8'h10, 8'h55);
    poke(8'h44, 8'h30, 8'hA2);
    poke(8'h46, 8'h40, 8'h18);  // JMP 18
    poke(8'h50, 8'h10, 8'h77);
    poke(8'h52, 8'h30, 8'hA4);
    poke(8'h54, 8'h42, 8'h00);  // RET to 42

    expect_wr(8'hA1, 8'h22, "R10 return after call");
    expect_wr(8'hA4, 8'h77, "R9 nested entry");
    expect_wr(8'hA2, 8'h55, "R11 nested overwrite");
    expect_wr(8'hA3, 8'h55, "R9 jump target");

    do_reset();
    run_to_halt("R12 halt after 0x00");

    // ---------- program 3: return straight after reset ----------
    clear_mem();
    poke(8'h00, 8'h42, 8'h00);  // RET to cleared address 0
    do_reset();
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (mem_addr_o > 8'h02 || halt_o || mem_we_o) begin
        check(1'b0, "R1 return register cleared", int'(mem_addr_o), 0);
        break;
      end
    end
    check(halt_o == 1'b0, "R11 loops at 0", int'(halt_o), 0);

    finish_run();
  end

endmodule